// File: doc/BRIEF.md
# Line Interface Mode Selector

This block decides which system-side interface a single line channel presents, and steers the channel's signals to match. Two interface families exist. In dual rail operation the positive and negative data rails travel separately, and the line codec is bypassed. In single rail operation one data rail passes through the line encoder and decoder, and a code violation flag is reported. Dual rail comes in two flavours. In the first, the recovered clock is forwarded. In the second, only raw slicing is done, and the receive clock pin carries the exclusive OR of the two unretimed slice rails, so that clock recovery can be done outside the block.

The host chooses raw slicing or the second single rail mode with two configuration bits. The first single rail mode is selected in-band instead: the system holds the negative transmit rail high for more than 16 transmit clock cycles in a row. The active mode is reported as a registered 2-bit code that is updated on the transmit clock. Code 00 is dual rail with recovered clock. Code 01 is dual rail raw slicing. Code 10 is single rail mode 1, detected from the pin. Code 11 is single rail mode 2, selected by the host, which also allows bipolar violations to be inserted.

Top module: `lim_mode_sel`

## Requirements
- R1: While rst_ni is low, mode_o is 00 and codec_en_o, cv_o, enc_bpv_o and enc_data_o are all 0.
- R2: With both host bits clear, mode_o changes to 10 at the clock edge that samples tx_neg_i high for the 17th consecutive time. After 16 consecutive high samples it is still 00.
- R3: The consecutive-high count saturates at 17. While tx_neg_i stays high, mode_o stays at 10 for any number of further cycles.
- R4: With both host bits clear, a single low sample of tx_neg_i returns mode_o to 00 at that same edge and restarts the count from zero.
- R5: If host_rsel_i and host_srail_i are both 1 at an edge, mode_o is 11 after that edge, whatever the state of tx_neg_i.
- R6: If host_rsel_i is 1 and host_srail_i is 0 at an edge, mode_o is 01 after that edge, and pin detection has no effect on it.
- R7: In mode 01, rclk_o equals rx_pos_i XOR rx_neg_i without any register delay. In every other mode, rclk_o follows rec_clk_i.
- R8: In modes 10 and 11, codec_en_o is 1, cv_o follows dec_cv_i, rx_pos_o follows dec_data_i and rx_neg_o is 0. In modes 00 and 01, codec_en_o is 0, cv_o is held 0, and rx_pos_o and rx_neg_o pass rx_pos_i and rx_neg_i through.
- R9: enc_bpv_o follows bpv_ins_i only in mode 11. In every other mode it is 0.
- R10: In single rail modes, enc_data_o carries tx_pos_i and tx_dp_o and tx_dn_o are 0. In dual rail modes, tx_dp_o and tx_dn_o carry tx_pos_i and tx_neg_i and enc_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_pos_i | input | 1 | Transmit data, positive rail (single rail data) |
| tx_neg_i | input | 1 | Transmit data, negative rail (in-band mode detect) |
| bpv_ins_i | input | 1 | Bipolar violation insert request |
| host_rsel_i | input | 1 | Host recovery-select bit |
| host_srail_i | input | 1 | Host single-rail bit |
| rx_pos_i | input | 1 | Receive positive slice/data rail |
| rx_neg_i | input | 1 | Receive negative slice/data rail |
| rec_clk_i | input | 1 | Recovered clock from clock recovery |
| dec_data_i | input | 1 | Decoded receive data from the line decoder |
| dec_cv_i | input | 1 | Code violation flag from the line decoder |
| mode_o | output | 2 | Active mode code (00, 01, 10, 11) |
| codec_en_o | output | 1 | Line encoder/decoder enable |
| enc_data_o | output | 1 | Data to the line encoder |
| enc_bpv_o | output | 1 | Violation insert to the line encoder |
| tx_dp_o | output | 1 | Dual rail transmit positive to the line side |
| tx_dn_o | output | 1 | Dual rail transmit negative to the line side |
| rx_pos_o | output | 1 | Receive data / positive rail to the system |
| rx_neg_o | output | 1 | Receive negative rail to the system |
| rclk_o | output | 1 | Receive clock pin |
| cv_o | output | 1 | Code violation pin |

## Verification
Every mode change shows on mode_o one clock edge after the inputs that cause it are sampled. For in-band detection, the edge that counts is the one sampling the 17th consecutive high or the first low. All routed outputs follow the registered mode and the current inputs combinationally, within the same cycle. The bench drives inputs shortly after each rising edge and updates a behavioural run-length and priority model on that edge. It then compares every output on the falling edge, after the mode register and the combinational routing have settled. Runs of exactly 16 and 17 highs, long saturated runs, and host overrides applied during a detected run are each driven on purpose.

// File: rtl/lim_mode_pkg.sv
package lim_mode_pkg;
  typedef enum logic [1:0] {
    MODE_DR_CLK = 2'b00,
    MODE_DR_RAW = 2'b01,
    MODE_SR1    = 2'b10,
    MODE_SR2    = 2'b11
  } lim_mode_e;

  function automatic logic is_single(lim_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/lim_run_detect.sv
module lim_run_detect #(
  parameter int RUN_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic run_full_o
);
  localparam int SAT = RUN_LEN + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!level_i)            cnt_d = '0;
    else if (cnt_q == SAT_V) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // looks at next count so the mode flips on the qualifying edge itself
  assign run_full_o = (cnt_d == SAT_V);

  assert_run_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT_V);
  assert_low_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i |=> cnt_q == '0);
endmodule

// File: rtl/lim_mode_reg.sv
module lim_mode_reg
  import lim_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_full_i,
  input  logic      host_rsel_i,
  input  logic      host_srail_i,
  output lim_mode_e mode_o
);
  lim_mode_e mode_d;

  // priority: host mode 2, host raw slicing, pin-detected mode 1, default
  always_comb begin
    if (host_rsel_i && host_srail_i) mode_d = MODE_SR2;
    else if (host_rsel_i)            mode_d = MODE_DR_RAW;
    else if (run_full_i)             mode_d = MODE_SR1;
    else                             mode_d = MODE_DR_CLK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_DR_CLK;
    else         mode_o <= mode_d;
  end

  assert_host_force_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rsel_i && host_srail_i) |=> mode_o == MODE_SR2);
  assert_raw_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rsel_i && !host_srail_i) |=> mode_o == MODE_DR_RAW);
endmodule

// File: rtl/lim_route.sv
module lim_route
  import lim_mode_pkg::*;
(
  input  lim_mode_e mode_i,
  input  logic      tx_pos_i,
  input  logic      tx_neg_i,
  input  logic      bpv_ins_i,
  input  logic      rx_pos_i,
  input  logic      rx_neg_i,
  input  logic      rec_clk_i,
  input  logic      dec_data_i,
  input  logic      dec_cv_i,
  output logic      codec_en_o,
  output logic      enc_data_o,
  output logic      enc_bpv_o,
  output logic      tx_dp_o,
  output logic      tx_dn_o,
  output logic      rx_pos_o,
  output logic      rx_neg_o,
  output logic      rclk_o,
  output logic      cv_o
);
  logic single;
  assign single = is_single(mode_i);

  always_comb begin
    codec_en_o = single;
    enc_data_o = single & tx_pos_i;
    enc_bpv_o  = (mode_i == MODE_SR2) & bpv_ins_i;
    tx_dp_o    = ~single & tx_pos_i;
    tx_dn_o    = ~single & tx_neg_i;
    rx_pos_o   = single ? dec_data_i : rx_pos_i;
    rx_neg_o   = ~single & rx_neg_i;
    cv_o       = single & dec_cv_i;
    rclk_o     = (mode_i == MODE_DR_RAW) ? (rx_pos_i ^ rx_neg_i) : rec_clk_i;
  end
endmodule

// File: rtl/lim_mode_sel.sv
module lim_mode_sel
  import lim_mode_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_pos_i,
  input  logic       tx_neg_i,
  input  logic       bpv_ins_i,
  input  logic       host_rsel_i,
  input  logic       host_srail_i,
  input  logic       rx_pos_i,
  input  logic       rx_neg_i,
  input  logic       rec_clk_i,
  input  logic       dec_data_i,
  input  logic       dec_cv_i,
  output logic [1:0] mode_o,
  output logic       codec_en_o,
  output logic       enc_data_o,
  output logic       enc_bpv_o,
  output logic       tx_dp_o,
  output logic       tx_dn_o,
  output logic       rx_pos_o,
  output logic       rx_neg_o,
  output logic       rclk_o,
  output logic       cv_o
);
  logic      run_full;
  lim_mode_e mode_q;

  lim_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (tx_neg_i),
    .run_full_o (run_full)
  );

  lim_mode_reg u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_full_i   (run_full),
    .host_rsel_i  (host_rsel_i),
    .host_srail_i (host_srail_i),
    .mode_o       (mode_q)
  );

  lim_route u_route (
    .mode_i     (mode_q),
    .tx_pos_i   (tx_pos_i),
    .tx_neg_i   (tx_neg_i),
    .bpv_ins_i  (bpv_ins_i),
    .rx_pos_i   (rx_pos_i),
    .rx_neg_i   (rx_neg_i),
    .rec_clk_i  (rec_clk_i),
    .dec_data_i (dec_data_i),
    .dec_cv_i   (dec_cv_i),
    .codec_en_o (codec_en_o),
    .enc_data_o (enc_data_o),
    .enc_bpv_o  (enc_bpv_o),
    .tx_dp_o    (tx_dp_o),
    .tx_dn_o    (tx_dn_o),
    .rx_pos_o   (rx_pos_o),
    .rx_neg_o   (rx_neg_o),
    .rclk_o     (rclk_o),
    .cv_o       (cv_o)
  );

  assign mode_o = mode_q;

  assert_pin_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_neg_i && !host_rsel_i) |=> mode_o == 2'b00);
  assert_cv_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rsel_i && !tx_neg_i) |=> !cv_o);
endmodule

// File: tb/tb_lim_mode_sel.sv
`timescale 1ns/1ps
module tb_lim_mode_sel;
  logic clk = 0, rst_n = 0;
  logic tx_pos = 0, tx_neg = 0, bpv = 0, hr = 0, hs = 0;
  logic rxp = 0, rxn = 0, rck = 0, dd = 0, dcv = 0;
  logic [1:0] mode;
  logic cen, encd, encb, tdp, tdn, rpo, rno, rclk, cv;

  int checks = 0, fails = 0;
  int run = 0;
  int exp_mode = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lim_mode_sel dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_pos_i(tx_pos), .tx_neg_i(tx_neg),
    .bpv_ins_i(bpv), .host_rsel_i(hr), .host_srail_i(hs), .rx_pos_i(rxp),
    .rx_neg_i(rxn), .rec_clk_i(rck), .dec_data_i(dd), .dec_cv_i(dcv),
    .mode_o(mode), .codec_en_o(cen), .enc_data_o(encd), .enc_bpv_o(encb),
    .tx_dp_o(tdp), .tx_dn_o(tdn), .rx_pos_o(rpo), .rx_neg_o(rno),
    .rclk_o(rclk), .cv_o(cv));

  // behavioural reference: run length and priority
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run = 0; exp_mode = 0;
    end else begin
      if (tx_neg) run = (run >= 17) ? 17 : run + 1; else run = 0;
      if (hr && hs)       exp_mode = 3;
      else if (hr)        exp_mode = 1;
      else if (run > 16)  exp_mode = 2;
      else                exp_mode = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // full comparison on every falling edge
  always @(negedge clk) if (rst_n) begin
    bit sgl;
    sgl = (exp_mode >= 2);
    cyc++;
    chk("R2/R3/R4/R5/R6", "mode", mode, exp_mode);
    chk("R7", "rclk", rclk, exp_mode == 1 ? int'(rxp ^ rxn) : int'(rck));
    chk("R8", "codec_en", cen, sgl);
    chk("R8", "cv", cv, sgl ? dcv : 0);
    chk("R8", "rx_pos", rpo, sgl ? dd : rxp);
    chk("R8", "rx_neg", rno, sgl ? 0 : rxn);
    chk("R9", "enc_bpv", encb, exp_mode == 3 ? bpv : 0);
    chk("R10", "enc_data", encd, sgl ? tx_pos : 0);
    chk("R10", "tx_dp", tdp, sgl ? 0 : tx_pos);
    chk("R10", "tx_dn", tdn, sgl ? 0 : tx_neg);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      {tx_pos, bpv, rxp, rxn, rck, dd, dcv} = 7'($urandom);
    end
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    {tx_pos, bpv, rxp, rxn, rck, dd, dcv} = 7'b1111111;
    #23;
    // R1 reset state
    chk("R1", "mode", mode, 0);
    chk("R1", "codec_en", cen, 0);
    chk("R1", "cv", cv, 0);
    chk("R1", "enc_bpv", encb, 0);
    chk("R1", "enc_data", encd, 0);
    @(posedge clk); #2 rst_n = 1;
    step(5);
    // R2: exactly 16 highs, then low
    tx_neg = 1; step(16);
    chk("R2", "mode after 16 highs", mode, 0);
    tx_neg = 0; step(3);
    // R2/R3: 17 highs then long run
    tx_neg = 1; step(17);
    chk("R2", "mode after 17 highs", mode, 2);
    step(40);
    chk("R3", "mode saturated run", mode, 2);
    // R4: single low sample
    tx_neg = 0; step(1);
    chk("R4", "mode after one low", mode, 0);
    tx_neg = 1; step(16);
    chk("R4", "count restarted", mode, 0);
    step(1);
    chk("R2", "re-entry", mode, 2);
    // R5 host override during detected run
    hr = 1; hs = 1; step(1);
    chk("R5", "host mode 2", mode, 3);
    tx_neg = 0; step(10);
    chk("R5", "host mode 2 with low pin", mode, 3);
    // R6 raw slicing ignores pin
    hs = 0; tx_neg = 1; step(30);
    chk("R6", "raw mode", mode, 1);
    hr = 0; step(1);
    chk("R6", "release to pin", mode, 2);
    tx_neg = 0; step(1);
    chk("R4", "back to default", mode, 0);
    // mixed stimulus
    for (int k = 0; k < 400; k++) begin
      tx_neg = ($urandom % 8) != 0;
      if (k % 97 == 0) {hr, hs} = 2'($urandom);
      step(1);
    end
    hr = 0; hs = 0; step(3);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule